// File: doc/BRIEF.md
# Flag-Mask Microinstruction Sequencer

This block is the control engine for a bank of execution modules that share one command bus. It reads 32-bit microwords from a microstore, splits each into two 16-bit microinstructions (the upper half first, the lower half second), and puts them on the command bus one per cycle in address order. The sequencer carries out two kinds of microinstruction itself and never places them on the bus. A conditional branch tests a masked slice of an 8-bit flag input and jumps by a short signed distance. A wait instruction holds the sequencer until every selected flag is set. Execution modules report that they are done through these flags.

The microaddress counts 16-bit halves. Bit 0 picks the half and the upper bits pick the microword. The microstore port has a fixed latency of one cycle. The command bus is a valid/ready stream. Once the valid strobe is high, the command stays on the bus unchanged until the cycle in which ready is high. The sequencer does not move past a command that has not been accepted. The flag input is plain level-sensitive control.

Top module: `flagmask_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the valid strobe is low. That first cycle reads microword 0. The upper half of word 0 is offered on the bus in the second cycle.
- R2: With no branch or wait and ready held high, one command is issued every cycle with no gaps, at microaddresses n, n+1, n+2 and so on. The address wraps modulo 2^ADDR_W.
- R3: A microinstruction with bits 15:14 = 01 is a branch, and one with bits 15:12 = 0011 is a wait. Every other 16-bit value, including 0000xxxx, 0001xxxx and 0010xxxx, is a command and appears on the bus bit for bit.
- R4: A branch takes its flag mask from bits 11:4 and its test code from bits 13:12. Code 00 jumps when the masked flags are all zero. Code 01 jumps when they are all one. Code 10 jumps unless they are all zero. Code 11 jumps unless they are all one.
- R5: The target of a taken branch is the branch's own microaddress plus bits 3:0 read as a signed 4-bit value, modulo 2^ADDR_W. A branch that is not taken continues at the next address.
- R6: A branch uses one cycle and issues nothing. A taken branch to an even target issues that target in the following cycle. An odd target costs one more empty cycle. A branch that is not taken issues the next address in the following cycle.
- R7: A wait takes its mask from bits 11:4. It holds on its own address, issuing nothing, until every masked flag is 1. It then moves to the next address. Unmasked flags have no effect, and a zero mask releases at once.
- R8: While valid is high and ready is low, the valid strobe and the command stay unchanged in the next cycle. Every command is accepted exactly once, in program order.
- R9: In a straight run, each microword is read from the microstore exactly once. A read happens in the reset-exit cycle, after each taken branch, and when the lower half of a word is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flags | input | 8 | Completion and condition flags from the execution modules |
| mem_rd_en | output | 1 | Microstore read request |
| mem_addr | output | ADDR_W-1 | Microword address for the read |
| mem_rdata | input | 32 | Microword, valid the cycle after the request |
| cmd_valid | output | 1 | A command is present on the bus |
| cmd_ready | input | 1 | The bus accepts the command this cycle |
| cmd_data | output | 16 | Command microinstruction |

## Verification
The bound assertions check four things in every cycle: the handshake hold rule, the address step after each accepted command, the reset-exit read of word 0, and the rule that an unsatisfied wait keeps the microaddress fixed. Which way each branch goes, where it lands, and what each taken branch costs in cycles can only be seen from the bench's scenarios. The bench sweeps all four test codes, all fifteen nonzero offsets and several flag patterns. It also tries waits on even and odd addresses across many masks and runs an irregular ready pattern.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int INSTR_W  = 16;
  localparam int WORD_W   = 32;
  localparam int FLAG_W   = 8;
  localparam int MASK_LSB = 4;
  localparam int OFS_W    = 4;

  typedef enum logic [1:0] {
    K_CMD    = 2'd0,
    K_BRANCH = 2'd1,
    K_WAIT   = 2'd2
  } ukind_e;

  typedef enum logic [1:0] {
    JMP_IF_CLEAR  = 2'd0,
    JMP_IF_FULL   = 2'd1,
    JMP_UNLESS_CL = 2'd2,
    JMP_UNLESS_FL = 2'd3
  } brtest_e;
endpackage

// File: rtl/ucseq_decode.sv
module ucseq_decode
  import ucseq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [FLAG_W-1:0]  flags,
  output ukind_e             kind,
  output logic               jump,
  output logic               wait_done,
  output logic [ADDR_W-1:0]  offset
);
  logic [FLAG_W-1:0] mask;
  logic [FLAG_W-1:0] sel;
  logic              none_set;
  logic              all_set;
  brtest_e           test;

  always_comb begin
    mask     = instr[MASK_LSB +: FLAG_W];
    sel      = flags & mask;
    none_set = (sel == '0);
    all_set  = (sel == mask);
    test     = brtest_e'(instr[13:12]);

    if (instr[15:14] == 2'b01)       kind = K_BRANCH;
    else if (instr[15:12] == 4'b0011) kind = K_WAIT;
    else                              kind = K_CMD;

    unique case (test)
      JMP_IF_CLEAR:  jump = none_set;
      JMP_IF_FULL:   jump = all_set;
      JMP_UNLESS_CL: jump = !none_set;
      JMP_UNLESS_FL: jump = !all_set;
    endcase

    wait_done = all_set;
    offset    = {{(ADDR_W-OFS_W){instr[OFS_W-1]}}, instr[OFS_W-1:0]};
  end
endmodule

// File: rtl/ucseq_fetch.sv
module ucseq_fetch
  import ucseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               half_sel,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               boot,
  output logic               fresh,
  output logic [INSTR_W-1:0] instr
);
  logic              boot_q;
  logic              fresh_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      fresh_q <= 1'b0;
      word_q  <= '0;
    end else begin
      boot_q  <= 1'b0;
      fresh_q <= load;
      if (fresh_q) word_q <= mem_rdata;
    end
  end

  always_comb begin
    word_cur = fresh_q ? mem_rdata : word_q;
    instr    = half_sel ? word_cur[INSTR_W-1:0] : word_cur[WORD_W-1:INSTR_W];
  end

  assign boot  = boot_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/ucseq_pc.sv
module ucseq_pc #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              taken,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] next_pc
);
  always_comb begin
    next_pc = taken ? (pc_q + offset) : (pc_q + ADDR_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (advance) pc_q <= next_pc;
  end
endmodule

// File: rtl/flagmask_seq.sv
module flagmask_seq
  import ucseq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FLAG_W-1:0]   flags,
  output logic                mem_rd_en,
  output logic [ADDR_W-2:0]   mem_addr,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [INSTR_W-1:0]  cmd_data
);
  logic               boot;
  logic               fresh;
  logic               active;
  logic               load;
  logic               advance;
  logic               taken;
  logic               jump;
  logic               wait_done;
  ukind_e             kind;
  logic [INSTR_W-1:0] instr;
  logic [ADDR_W-1:0]  offset;
  logic [ADDR_W-1:0]  pc_q;
  logic [ADDR_W-1:0]  next_pc;

  ucseq_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .half_sel  (pc_q[0]),
    .mem_rdata (mem_rdata),
    .boot      (boot),
    .fresh     (fresh),
    .instr     (instr)
  );

  ucseq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr     (instr),
    .flags     (flags),
    .kind      (kind),
    .jump      (jump),
    .wait_done (wait_done),
    .offset    (offset)
  );

  ucseq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .taken   (taken),
    .offset  (offset),
    .pc_q    (pc_q),
    .next_pc (next_pc)
  );

  // A freshly loaded word always presents its upper half first; an odd
  // target therefore spends one cycle stepping over it.
  always_comb begin
    active = !boot && !(fresh && pc_q[0]);
    taken  = active && (kind == K_BRANCH) && jump;
    unique case (kind)
      K_CMD:   advance = active && cmd_ready;
      K_WAIT:  advance = active && wait_done;
      default: advance = active;
    endcase
    load      = boot || (advance && (taken || pc_q[0]));
    mem_rd_en = load;
    mem_addr  = boot ? pc_q[ADDR_W-1:1] : next_pc[ADDR_W-1:1];
    cmd_valid = active && (kind == K_CMD);
    cmd_data  = instr;
  end
endmodule

// File: rtl/flagmask_seq_chk.sv
module flagmask_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        flags,
  input logic              mem_rd_en,
  input logic [ADDR_W-2:0] mem_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [15:0]       cmd_data,
  input logic              exec_active,
  input logic [15:0]       instr,
  input logic [ADDR_W-1:0] pc_q
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= 1'b0;
  end

  assert_boot_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> (mem_rd_en && (mem_addr == '0) && !cmd_valid));

  assert_step_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && (instr[15:12] == 4'b0011) && ((flags & instr[11:4]) != instr[11:4]))
      |=> $stable(pc_q));

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));
endmodule

bind flagmask_seq flagmask_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flags       (flags),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_data    (cmd_data),
  .exec_active (active),
  .instr       (instr),
  .pc_q        (pc_q)
);

// File: tb/flagmask_seq_tb.sv
module flagmask_seq_tb;
  localparam int AW = 6;
  localparam int NW = 1 << (AW - 1);
  localparam int NH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [7:0]    flags = '0;
  logic          cmd_ready = 1'b1;
  logic          mem_rd_en;
  logic [AW-2:0] mem_addr;
  logic [31:0]   mem_rdata = '0;
  logic          cmd_valid;
  logic [15:0]   cmd_data;

  logic [31:0] mem [NW];
  logic [15:0] img [NH];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nlog   = 0;
  int nreads = 0;
  logic [15:0] log_d [512];
  int          log_c [512];

  flagmask_seq #(.ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; nlog = 0; nreads = 0;
    end else begin
      if (mem_rd_en && cyc <= 40) nreads++;
      if (cmd_valid && cmd_ready && nlog < 512) begin
        log_d[nlog] = cmd_data;
        log_c[nlog] = cyc;
        nlog++;
      end
      cyc++;
    end
  end

  function automatic logic [15:0] mark(int a);
    return 16'h8000 | 16'(a);
  endfunction

  task automatic put(int a, logic [15:0] v);
    img[a] = v;
    if (a % 2 == 1) mem[a / 2][15:0] = v;
    else            mem[a / 2][31:16] = v;
  endtask

  task automatic fill_marks();
    for (int a = 0; a < NH; a++) put(a, mark(a));
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start();
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic stop();
    @(posedge clk); #1 rst_n = 1'b0; flags = '0; cmd_ready = 1'b1;
    @(posedge clk); @(posedge clk);
  endtask

  task automatic run_to(int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic bit pat(int k);
    return (k % 3 != 2) && (k % 7 != 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);

    // R1, R2, R3, R9: straight stream with a few low-prefix commands
    fill_marks();
    put(3, 16'h0123); put(6, 16'h2abc); put(7, 16'h1fff);
    start();
    @(negedge clk); #0;
    chk(mem_rd_en && mem_addr == '0 && !cmd_valid, "R1 boot read", int'(mem_rd_en), 1);
    @(negedge clk); #0;
    chk(cmd_valid && cmd_data == img[0], "R1 first issue", int'(cmd_data), int'(img[0]));
    run_to(72);
    chk(nlog >= 70, "R2 issue count", nlog, 70);
    for (int i = 0; i < 70; i++) begin
      chk(log_d[i] == img[i % NH], "R2 R3 order/data", int'(log_d[i]), int'(img[i % NH]));
      chk(log_c[i] == i + 1, "R2 no gaps", log_c[i], i + 1);
    end
    chk(nreads == 21, "R9 one read per word", nreads, 21);
    stop();

    // R4, R5, R6: branch at odd address 9, all codes, offsets, flag patterns
    for (int op = 0; op < 4; op++) begin
      for (int inc = 1; inc < 16; inc++) begin
        for (int p = 0; p < 4; p++) begin
          logic [7:0] fv;
          bit nz, al, tk;
          int s, t, ea, ec;
          fv = (p == 0) ? 8'h00 : (p == 1) ? 8'hF0 : (p == 2) ? 8'h30 : 8'h0F;
          nz = ((fv & 8'hF0) == 8'h00);
          al = ((fv & 8'hF0) == 8'hF0);
          tk = (op == 0) ? nz : (op == 1) ? al : (op == 2) ? !nz : !al;
          s  = (inc >= 8) ? inc - 16 : inc;
          t  = (9 + s + NH) % NH;
          ea = tk ? t : 10;
          ec = tk ? 11 + (t % 2) : 11;
          fill_marks();
          put(9, {2'b01, 2'(op), 8'hF0, 4'(inc)});
          flags = fv;
          start();
          run_to(14);
          chk(nlog > 9 && log_d[9] == img[ea], "R4 R5 branch outcome", int'(log_d[9]), int'(img[ea]));
          chk(log_c[9] == ec, "R6 branch timing", log_c[9], ec);
          stop();
        end
      end
    end

    // R5, R6: backward branch wrapping below zero to an odd target
    fill_marks();
    put(1, {2'b01, 2'b00, 8'h00, 4'hC});
    start();
    run_to(8);
    chk(log_d[1] == img[61] && log_c[1] == 4, "R5 wrap target", int'(log_d[1]), int'(img[61]));
    chk(log_d[2] == img[62] && log_c[2] == 5, "R6 after odd target", log_c[2], 5);
    stop();

    // R7: waits at even and odd addresses over many masks
    for (int w = 4; w < 6; w++) begin
      for (int mi = 0; mi < 11; mi++) begin
        logic [7:0] m;
        m = (mi == 0) ? 8'h00 : (mi <= 8) ? 8'(1 << (mi - 1)) : (mi == 9) ? 8'hFF : 8'hA5;
        fill_marks();
        put(w, {4'b0011, m, 4'h0});
        start();
        if (m == 8'h00) begin
          run_to(10);
          chk(log_d[w] == img[w + 1] && log_c[w] == w + 2, "R7 zero mask", log_c[w], w + 2);
        end else begin
          run_to(8);
          flags = (m & (m - 8'h01)) | ~m;
          run_to(12);
          chk(nlog == w, "R7 held on partial flags", nlog, w);
          flags = m;
          run_to(16);
          chk(log_d[w] == img[w + 1], "R7 resumes next", int'(log_d[w]), int'(img[w + 1]));
          chk(log_c[w] == 13, "R7 release timing", log_c[w], 13);
        end
        stop();
      end
    end

    // R8: irregular back-pressure on a straight stream
    begin
      int expct;
      int acc;
      expct = 0;
      fill_marks();
      cmd_ready = pat(0);
      start();
      for (int k = 1; k < 120; k++) begin
        @(posedge clk); #1 cmd_ready = pat(k);
        if (pat(k)) expct++;
      end
      @(posedge clk); #1 cmd_ready = 1'b1;
      run_to(122);
      acc = 0;
      for (int i = 0; i < nlog; i++) if (log_c[i] <= 119) acc++;
      chk(acc == expct, "R8 accept count", acc, expct);
      for (int i = 0; i < 40; i++)
        chk(log_d[i] == img[i % NH], "R8 order under stall", int'(log_d[i]), int'(img[i % NH]));
      stop();
    end

    report();
    $finish;
  end
endmodule